// File: doc/BRIEF.md
# Expansion memory bank select decoder

This block sits on an expansion board that carries two 16 KiB memories: an EPROM that can only be read and a battery-backed SRAM. The host selects an expansion bank by writing a byte to an I/O port. The port is decoded from the upper address byte DFh alone. When the stored bank number matches one of three jumper-set values, the board answers memory cycles in the top 16 KiB of the address space, C000h to FFFFh.

The comparisons are not symmetric. The EPROM compares the full byte. The SRAM read match and the SRAM write match each compare only the low nibble, each against its own jumper nibble. A board read needs the host's upper-ROM-enable strobe to be active. An SRAM write does not need it, and it does not block the host's own RAM, so the host RAM receives the same write.

All memory-side outputs are combinational functions of the bus strobes and the stored bank byte, so they add no cycles of latency. The bank register is the only sequential state. A clock samples the bus to find the rising edge of the I/O write strobe.

Top module: `bank_sel_top`

## Requirements
- R1: An I/O write with `iorq_ni`=0, `wr_ni`=0 and `addr_i[15:8]`=DFh, whatever `addr_i[7:0]` is, loads `data_i` into the bank register. The new value is visible on the first clock edge at which `wr_ni` is sampled high after the write. I/O writes to any other upper byte leave the register unchanged.
- R2: Reset (`rst_ni`=0) clears the bank register to 00h.
- R3: No chip enable is asserted unless `addr_i[15:14]`=2'b11 and `mreq_ni`=0. I/O cycles never enable a memory.
- R4: `eprom_ce_no` is 0 when all 8 bank bits equal `eprom_bank_i`, `mreq_ni`=0, `rd_ni`=0 and `romen_ni`=0, with the address in the window. A bank that differs in any single bit does not enable the EPROM.
- R5: An SRAM read (`sram_ce_no`=0, `sram_we_no`=1) happens when bank bits 3:0 equal `sram_rd_bank_i` under the same read conditions as R4. Bank bits 7:4 are ignored.
- R6: An SRAM write (`sram_ce_no`=0 and `sram_we_no`=0) happens when bank bits 3:0 equal `sram_wr_bank_i`, `mreq_ni`=0 and `wr_ni`=0 in the window, whatever the level of `romen_ni`. Bank bits 7:4 are ignored. `bus_drive_o` and `rom_dis_o` stay 0 during the write.
- R7: When the EPROM match and the SRAM read match hold together, only the EPROM is enabled.
- R8: `bus_drive_o` and `rom_dis_o` are 1 exactly while a board read (R4 or R5) is active, and 0 otherwise. With `romen_ni`=1 there is no board read.
- R9: All outputs react within the same cycle as the strobes change, with no register between the bus inputs and the memory-side outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the port-write edge detector |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Host address bus |
| data_i | input | 8 | Host data bus |
| iorq_ni | input | 1 | I/O request strobe, active low |
| mreq_ni | input | 1 | Memory request strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| romen_ni | input | 1 | Host upper-ROM-enable strobe, active low |
| eprom_bank_i | input | 8 | Jumper byte for the EPROM bank |
| sram_rd_bank_i | input | 4 | Jumper nibble for the SRAM read bank |
| sram_wr_bank_i | input | 4 | Jumper nibble for the SRAM write bank |
| eprom_ce_no | output | 1 | EPROM chip enable, active low |
| sram_ce_no | output | 1 | SRAM chip enable, active low |
| sram_we_no | output | 1 | SRAM write enable, active low |
| bus_drive_o | output | 1 | Enables the board's data-bus drivers |
| rom_dis_o | output | 1 | Disables the host's internal ROM |

## Verification
Two functions can fall in the same cycle. The first case is a read where the EPROM full-byte match and the SRAM nibble match both hold. The bench provokes it by setting the SRAM read jumper to the low nibble of the EPROM jumper, and it passes only if the EPROM alone is enabled. The second case is a bank-register update that retires on the edge just before a memory access. The bench places a memory read right after the port write and checks that the access is decoded against the new bank, on the cycle in which the register is expected to change. A behavioural model compares all five outputs on every clock.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;
  typedef struct packed {
    logic eprom_rd;
    logic sram_rd;
    logic sram_wr;
  } access_t;
endpackage

// File: rtl/bank_sel_reg.sv
module bank_sel_reg #(
  parameter int          HI_W    = 8,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  PORT_HI = 8'hDF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iorq_ni,
  input  logic              wr_ni,
  output logic [DATA_W-1:0] bank_o
);
  logic              hit_now;
  logic              pend_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] bank_q;

  assign hit_now = !iorq_ni && !wr_ni && (addr_hi_i == HI_W'(PORT_HI));

  // commit on the first sample after the write strobe is released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
      bank_q <= '0;
    end else begin
      if (pend_q && wr_ni) bank_q <= data_q;
      pend_q <= hit_now;
      if (hit_now) data_q <= data_i;
    end
  end

  assign bank_o = bank_q;

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q && wr_ni) |=> $stable(bank_q)) else $error("bank changed without port write"); // R1
endmodule

// File: rtl/bank_sel_match.sv
module bank_sel_match #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] bank_i,
  input  logic [DATA_W-1:0] eprom_bank_i,
  input  logic [NIB_W-1:0]  sram_rd_bank_i,
  input  logic [NIB_W-1:0]  sram_wr_bank_i,
  output logic              eprom_hit_o,
  output logic              sram_rd_hit_o,
  output logic              sram_wr_hit_o
);
  logic [DATA_W-1:0] eq_full;
  logic [NIB_W-1:0]  eq_rd;
  logic [NIB_W-1:0]  eq_wr;

  for (genvar i = 0; i < DATA_W; i++) begin : g_full
    assign eq_full[i] = bank_i[i] ~^ eprom_bank_i[i];
  end
  for (genvar i = 0; i < NIB_W; i++) begin : g_nib
    assign eq_rd[i] = bank_i[i] ~^ sram_rd_bank_i[i];
    assign eq_wr[i] = bank_i[i] ~^ sram_wr_bank_i[i];
  end

  assign eprom_hit_o   = &eq_full;
  assign sram_rd_hit_o = &eq_rd;
  assign sram_wr_hit_o = &eq_wr;
endmodule

// File: rtl/bank_sel_access.sv
module bank_sel_access
  import bank_sel_pkg::*;
(
  input  logic    win_i,
  input  logic    mreq_ni,
  input  logic    rd_ni,
  input  logic    wr_ni,
  input  logic    romen_ni,
  input  logic    eprom_hit_i,
  input  logic    sram_rd_hit_i,
  input  logic    sram_wr_hit_i,
  output access_t acc_o
);
  logic mem_cyc;
  logic rd_cyc;

  assign mem_cyc = win_i && !mreq_ni;
  assign rd_cyc  = mem_cyc && !rd_ni && !romen_ni;

  always_comb begin
    acc_o.eprom_rd = rd_cyc && eprom_hit_i;
    acc_o.sram_rd  = rd_cyc && sram_rd_hit_i && !eprom_hit_i;
    acc_o.sram_wr  = mem_cyc && !wr_ni && sram_wr_hit_i;
  end
endmodule

// File: rtl/bank_sel_top.sv
module bank_sel_top
  import bank_sel_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         DATA_W  = 8,
  parameter int         NIB_W   = 4,
  parameter int         WIN_W   = 2,
  parameter logic [7:0] PORT_HI = 8'hDF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iorq_ni,
  input  logic              mreq_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              romen_ni,
  input  logic [DATA_W-1:0] eprom_bank_i,
  input  logic [NIB_W-1:0]  sram_rd_bank_i,
  input  logic [NIB_W-1:0]  sram_wr_bank_i,
  output logic              eprom_ce_no,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              bus_drive_o,
  output logic              rom_dis_o
);
  localparam int HI_W = ADDR_W / 2;

  logic [DATA_W-1:0] bank;
  logic              win;
  logic              e_hit, r_hit, w_hit;
  access_t           acc;
  logic              unused_lo;

  assign unused_lo = ^addr_i[HI_W-1:0];
  assign win       = &addr_i[ADDR_W-1 -: WIN_W];

  bank_sel_reg #(.HI_W(HI_W), .DATA_W(DATA_W), .PORT_HI(PORT_HI)) u_reg (
    .clk_i, .rst_ni,
    .addr_hi_i (addr_i[ADDR_W-1 -: HI_W]),
    .data_i, .iorq_ni, .wr_ni,
    .bank_o    (bank)
  );

  bank_sel_match #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_match (
    .bank_i (bank), .eprom_bank_i, .sram_rd_bank_i, .sram_wr_bank_i,
    .eprom_hit_o (e_hit), .sram_rd_hit_o (r_hit), .sram_wr_hit_o (w_hit)
  );

  bank_sel_access u_acc (
    .win_i (win), .mreq_ni, .rd_ni, .wr_ni, .romen_ni,
    .eprom_hit_i (e_hit), .sram_rd_hit_i (r_hit), .sram_wr_hit_i (w_hit),
    .acc_o (acc)
  );

  assign eprom_ce_no = !acc.eprom_rd;
  assign sram_ce_no  = !(acc.sram_rd || acc.sram_wr);
  assign sram_we_no  = !acc.sram_wr;
  assign bus_drive_o = acc.eprom_rd || acc.sram_rd;
  assign rom_dis_o   = acc.eprom_rd || acc.sram_rd;

  AST_SINGLE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!eprom_ce_no && !sram_ce_no)) else $error("both memories enabled"); // R7
  AST_WE_WITH_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_ce_no && !bus_drive_o)) else $error("write without ce"); // R6
  AST_DRIVE_NEEDS_ROMEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_o |-> (!romen_ni && !rd_ni && !mreq_ni)) else $error("drive outside read"); // R8
  AST_WIN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eprom_ce_no || !sram_ce_no) |-> (addr_i[ADDR_W-1 -: WIN_W] == '1 && !mreq_ni))
    else $error("enable outside window"); // R3
endmodule

// File: tb/bank_sel_top_tb.sv
`timescale 1ns/1ps
module bank_sel_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, romen_n = 1'b1;
  logic [7:0]  ej = 8'h3A;
  logic [3:0]  srj = 4'h5, swj = 4'h9;
  logic        e_ce, s_ce, s_we, drv, rdis;

  int total = 0, bad = 0;
  string cur = "R2";
  bit done = 0;

  int m_bank = 0, m_pend = 0, m_pdata = 0;

  always #2.5 clk = ~clk;

  bank_sel_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
    .iorq_ni(iorq_n), .mreq_ni(mreq_n), .rd_ni(rd_n), .wr_ni(wr_n), .romen_ni(romen_n),
    .eprom_bank_i(ej), .sram_rd_bank_i(srj), .sram_wr_bank_i(swj),
    .eprom_ce_no(e_ce), .sram_ce_no(s_ce), .sram_we_no(s_we),
    .bus_drive_o(drv), .rom_dis_o(rdis)
  );

  // reference: bank byte becomes the port data once the write strobe is seen released
  always @(posedge clk) begin
    if (!rst_n) begin
      m_bank = 0; m_pend = 0;
    end else begin
      if (m_pend != 0 && wr_n) m_bank = m_pdata;
      m_pend = (!iorq_n && !wr_n && addr[15:8] == 8'hDF) ? 1 : 0;
      if (m_pend != 0) m_pdata = data;
    end
  end

  always @(negedge clk) begin
    bit win, er, sr, sw;
    logic [4:0] got, exp;
    win = (addr >= 16'hC000) && !mreq_n;
    er  = win && !rd_n && !romen_n && (m_bank == ej);
    sr  = win && !rd_n && !romen_n && ((m_bank % 16) == srj) && !er;
    sw  = win && !wr_n && ((m_bank % 16) == swj);
    exp = {!er, !(sr || sw), !sw, er || sr, er || sr};
    got = {e_ce, s_ce, s_we, drv, rdis};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s t=%0t ce_e/ce_s/we/drv/dis got=%b exp=%b bank=%02h",
               cur, $time, got, exp, m_bank[7:0]);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      iorq_n = 1; mreq_n = 1; rd_n = 1; wr_n = 1;
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; data = d; iorq_n = 0; wr_n = 0; mreq_n = 1; rd_n = 1;
    @(posedge clk); #1;
    iorq_n = 1; wr_n = 1;
  endtask

  task automatic mem_rd(input logic [15:0] a, input logic re);
    @(posedge clk); #1;
    addr = a; romen_n = re; mreq_n = 0; rd_n = 0;
    @(posedge clk); #1;
    mreq_n = 1; rd_n = 1; romen_n = 1;
  endtask

  task automatic mem_wr(input logic [15:0] a, input logic re);
    @(posedge clk); #1;
    addr = a; romen_n = re; mreq_n = 0; wr_n = 0;
    @(posedge clk); #1;
    mreq_n = 1; wr_n = 1; romen_n = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    mem_rd(16'hC000, 1'b0);             // R2: bank 00h, nothing matches
    #1 rst_n = 1;
    cur = "R2"; mem_rd(16'hC000, 1'b0);
    cur = "R1"; io_wr(16'hDF12, 8'h3A); mem_rd(16'hC123, 1'b0);   // R1 then R4 back to back
    cur = "R1"; io_wr(16'hDE00, 8'h00); idle(1); mem_rd(16'hC001, 1'b0);
    cur = "R1"; io_wr(16'hDFFF, 8'h3A); idle(1); mem_rd(16'hE000, 1'b0);
    cur = "R3"; mem_rd(16'hBFFF, 1'b0); mem_rd(16'h8000, 1'b0); mem_rd(16'hFFFF, 1'b0);
    cur = "R3"; @(posedge clk); #1; addr = 16'hC000; iorq_n = 0; rd_n = 0; idle(1);
    cur = "R8"; mem_rd(16'hC010, 1'b1);
    cur = "R4"; io_wr(16'hDF00, 8'h3B); idle(1); mem_rd(16'hC000, 1'b0);
    cur = "R4"; io_wr(16'hDF00, 8'hBA); idle(1); mem_rd(16'hC000, 1'b0);
    cur = "R5"; io_wr(16'hDF00, 8'h75); idle(1); mem_rd(16'hD000, 1'b0);
    cur = "R5"; io_wr(16'hDF00, 8'hF5); idle(1); mem_rd(16'hD000, 1'b0); mem_rd(16'hD000, 1'b1);
    cur = "R6"; io_wr(16'hDF00, 8'h29); idle(1); mem_wr(16'hC000, 1'b1); mem_wr(16'hC000, 1'b0);
    cur = "R6"; io_wr(16'hDF00, 8'h19); idle(1); mem_wr(16'hFFFE, 1'b1); mem_wr(16'h4000, 1'b1);
    cur = "R6"; io_wr(16'hDF00, 8'h2A); idle(1); mem_wr(16'hC000, 1'b1);
    cur = "R7"; srj = 4'hA; io_wr(16'hDF00, 8'h3A); idle(1); mem_rd(16'hC000, 1'b0);
    cur = "R7"; io_wr(16'hDF00, 8'h4A); idle(1); mem_rd(16'hC000, 1'b0);
    cur = "R9"; @(posedge clk); #1; addr = 16'hC000; mreq_n = 0; rd_n = 0; romen_n = 0;
    #1 romen_n = 1; idle(1);
    cur = "R2"; #1 rst_n = 0; idle(2); #1 rst_n = 1; mem_rd(16'hC000, 1'b0);
    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired in %s", cur);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule